// File: doc/BRIEF.md
# Time-Multiplexed Wavetable Oscillator Bank

This block is a bank of sixteen digital oscillator slots (eight voices with two oscillators each) that share one phase adder, one small channel store and one wavetable. A clock-enable divider services one slot at a time, in a fixed round-robin order. Each slot repeats every 16 ticks, so a full round of all slots forms one sample period. With the parameters set for the system clock, that period is 50 kHz. During its service the slot adds its 18-bit phase step to its 18-bit phase, which wraps modulo 2^18, and writes the sum back. The top 8 bits of the new phase then address the wavetable. The increment for a pitch f is round(2^18 * f / 50000).

The wavetable is a generated sine held as a 256-entry ROM. Each slot carries a 3-bit octave number and a 1-bit tone select. A pure tone reads the sine directly. A bright tone averages the sine with one harmonic of it. The harmonic number is set by the octave, so low octaves sound richer and high octaves purer. Each 8-bit sample leaves the block with its slot number on a valid/ready stream, ready for an external DAC and sample-hold demultiplexer. A second valid/ready stream loads a slot's increment, octave and tone. Output amplitude is constant.

Back-pressure rules: the oscillator is a real-time source and never stalls. While `smp_valid` is high and `smp_ready` is low, the sample and slot are held. A newer sample replaces an unaccepted one, and phases keep advancing. On the load side, `cfg_ready` drops only in the one clock where the addressed slot is being serviced, and the load then completes on a later clock.

Top module: `tdm_wave_osc`

## Requirements
- R1: After reset every phase, increment, octave and tone is zero, `smp_valid` is 0 and `cfg_ready` is 1. The first sample produced is for slot 0 with value 128.
- R2: One slot is serviced every SLOT_DIV clocks (default 8). The first service comes SLOT_DIV clocks after reset release, and slots are taken in ascending order 0..15, wrapping to 0.
- R3: A service replaces the slot's phase by (phase + increment) mod 2^18, and no other slot's phase changes.
- R4: The sample index is bits 17..10 of the updated phase.
- R5: The base table entry for index i (0..255) is 128+p for i<128 and 128-p for i>=128, where q = i mod 128 and p = floor(q*(127-q)/32).
- R6: Tone 0 outputs base(i). Tone 1 outputs floor((base(i) + base(j))/2), where j = (i * 2^k) mod 256 and k = floor((7 - octave)/2).
- R7: The clock edge that ends a service loads `smp_valid`=1, `smp_slot` and `smp_data` for that slot.
- R8: While `smp_valid`=1 and `smp_ready`=0, slot and data stay stable until the next service replaces them. An accepted sample clears `smp_valid` on the following edge when no service falls there.
- R9: `cfg_ready` is 0 exactly when `cfg_slot` names the slot in service. An accepted load changes the increment, octave and tone of that slot but never its phase, and takes effect from the slot's next service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Load request for one slot |
| cfg_ready | output | 1 | Load accepted at this edge when high with cfg_valid |
| cfg_slot | input | 4 | Slot to load |
| cfg_step | input | 18 | Phase increment per sample |
| cfg_octave | input | 3 | Octave number selecting the harmonic |
| cfg_tone | input | 1 | 0 pure sine, 1 sine plus octave harmonic |
| smp_valid | output | 1 | Sample available |
| smp_ready | input | 1 | Downstream takes the sample |
| smp_slot | output | 4 | Slot the sample belongs to |
| smp_data | output | 8 | Offset-binary sample |

## Verification
The two functions that can meet in one clock are a slot's read-modify-write service and a load aimed at that same slot. The bench watches the sample stream for the slot just before its target. It counts SLOT_DIV clocks and raises a load for the target exactly in its service clock. It then judges that `cfg_ready` is low in that clock and high in the next. It also judges that the sample emitted by that service still uses the old increment, and that later samples follow the new increment from the unchanged phase.

// File: rtl/tdm_osc_pkg.sv
package tdm_osc_pkg;

  localparam int unsigned OCT_W  = 3;
  localparam int unsigned TONE_W = 1;

  typedef struct packed {
    logic [OCT_W-1:0]  octave;
    logic [TONE_W-1:0] tone;
  } voice_sel_t;

  // Parabolic half-wave sine, offset binary, evaluated at elaboration.
  function automatic int unsigned base_sine(int unsigned pos, int unsigned idx_w,
                                            int unsigned samp_w);
    longint unsigned half, q, bump, mag, mid;
    half = longint'(64'd1) << (idx_w - 1);
    q    = longint'(pos) % half;
    bump = q * (half - 1 - q);
    mag  = (bump << samp_w) >> (2 * idx_w - 3);
    mid  = longint'(64'd1) << (samp_w - 1);
    if (longint'(pos) >= half) return int'(mid - mag);
    return int'(mid + mag);
  endfunction

endpackage

// File: rtl/tdm_osc_slot_timer.sv
module tdm_osc_slot_timer #(
  parameter int unsigned SLOTS    = 16,
  parameter int unsigned SLOT_DIV = 8,
  localparam int unsigned SLOT_W  = $clog2(SLOTS),
  localparam int unsigned DIV_W   = $clog2(SLOT_DIV)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              tick,
  output logic [SLOT_W-1:0] slot
);

  localparam logic [DIV_W-1:0]  DIV_LAST  = DIV_W'(SLOT_DIV - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);

  logic [DIV_W-1:0] div_cnt;

  assign tick = (div_cnt == DIV_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt <= '0;
      slot    <= '0;
    end else if (tick) begin
      div_cnt <= '0;
      slot    <= (slot == SLOT_LAST) ? '0 : slot + 1'b1;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);  // R2
  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(slot));  // R2

endmodule

// File: rtl/tdm_osc_chan_ram.sv
module tdm_osc_chan_ram
  import tdm_osc_pkg::*;
#(
  parameter int unsigned SLOTS   = 16,
  parameter int unsigned PHASE_W = 18,
  parameter int unsigned IDX_W   = 8,
  localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [SLOT_W-1:0]  slot,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [SLOT_W-1:0]  wr_slot,
  input  logic [PHASE_W-1:0] wr_step,
  input  voice_sel_t         wr_sel,
  output logic [IDX_W-1:0]   cur_idx,
  output voice_sel_t         cur_sel
);

  logic [PHASE_W-1:0] ph_mem   [SLOTS];
  logic [PHASE_W-1:0] step_mem [SLOTS];
  voice_sel_t         sel_mem  [SLOTS];

  logic [PHASE_W-1:0] next_ph;
  logic               wr_fire;

  assign next_ph  = ph_mem[slot] + step_mem[slot];
  assign cur_idx  = next_ph[PHASE_W-1 -: IDX_W];
  assign cur_sel  = sel_mem[slot];
  assign wr_ready = !(tick && (wr_slot == slot));
  assign wr_fire  = wr_valid && wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) begin
        ph_mem[i]   <= '0;
        step_mem[i] <= '0;
        sel_mem[i]  <= '0;
      end
    end else begin
      if (tick) ph_mem[slot] <= next_ph;
      if (wr_fire) begin
        step_mem[wr_slot] <= wr_step;
        sel_mem[wr_slot]  <= wr_sel;
      end
    end
  end

  AST_LOAD_KEEPS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> ph_mem[$past(wr_slot)] == $past(ph_mem[wr_slot]));  // R9
  AST_IDLE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ph_mem[$past(slot)] == $past(ph_mem[slot]));  // R3

endmodule

// File: rtl/tdm_osc_wavetable.sv
module tdm_osc_wavetable
  import tdm_osc_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned SAMP_W = 8,
  localparam int unsigned DEPTH = 1 << IDX_W,
  localparam int unsigned HSH_W = OCT_W - 1
) (
  input  logic [IDX_W-1:0]  idx,
  input  voice_sel_t        sel,
  output logic [SAMP_W-1:0] sample
);

  logic [SAMP_W-1:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    assign rom[g] = SAMP_W'(base_sine(g, IDX_W, SAMP_W));
  end

  logic [HSH_W-1:0]  hsh;
  logic [IDX_W-1:0]  hidx;
  logic [SAMP_W-1:0] fund, harm;
  logic [SAMP_W:0]   acc;

  // Higher octaves take a lower harmonic: shift = (max_octave - octave) / 2.
  assign hsh  = HSH_W'((~sel.octave) >> 1);
  assign hidx = idx << hsh;
  assign fund = rom[idx];
  assign harm = rom[hidx];
  assign acc  = {1'b0, fund} + {1'b0, harm};

  always_comb begin
    if (sel.tone[0]) sample = acc[SAMP_W:1];
    else             sample = fund;
  end

endmodule

// File: rtl/tdm_osc_out_stage.sv
module tdm_osc_out_stage #(
  parameter int unsigned SLOT_W = 4,
  parameter int unsigned SAMP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SLOT_W-1:0] in_slot,
  input  logic [SAMP_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [SLOT_W-1:0] out_slot,
  output logic [SAMP_W-1:0] out_data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_slot  <= '0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_slot  <= in_slot;
      out_data  <= in_data;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !load) |=> out_valid && $stable(out_data) && $stable(out_slot));  // R8
  AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !load) |=> !out_valid);  // R8

endmodule

// File: rtl/tdm_wave_osc.sv
module tdm_wave_osc
  import tdm_osc_pkg::*;
#(
  parameter int unsigned SLOTS    = 16,
  parameter int unsigned SLOT_DIV = 8,
  parameter int unsigned PHASE_W  = 18,
  parameter int unsigned IDX_W    = 8,
  parameter int unsigned SAMP_W   = 8,
  localparam int unsigned SLOT_W  = $clog2(SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_valid,
  output logic               cfg_ready,
  input  logic [SLOT_W-1:0]  cfg_slot,
  input  logic [PHASE_W-1:0] cfg_step,
  input  logic [OCT_W-1:0]   cfg_octave,
  input  logic [TONE_W-1:0]  cfg_tone,
  output logic               smp_valid,
  input  logic               smp_ready,
  output logic [SLOT_W-1:0]  smp_slot,
  output logic [SAMP_W-1:0]  smp_data
);

  logic              tick;
  logic [SLOT_W-1:0] slot;
  logic [IDX_W-1:0]  cur_idx;
  voice_sel_t        cur_sel, wr_sel;
  logic [SAMP_W-1:0] cur_sample;

  assign wr_sel = '{octave: cfg_octave, tone: cfg_tone};

  tdm_osc_slot_timer #(.SLOTS(SLOTS), .SLOT_DIV(SLOT_DIV)) i_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .slot(slot)
  );

  tdm_osc_chan_ram #(.SLOTS(SLOTS), .PHASE_W(PHASE_W), .IDX_W(IDX_W)) i_ram (
    .clk(clk), .rst_n(rst_n), .tick(tick), .slot(slot),
    .wr_valid(cfg_valid), .wr_ready(cfg_ready), .wr_slot(cfg_slot),
    .wr_step(cfg_step), .wr_sel(wr_sel),
    .cur_idx(cur_idx), .cur_sel(cur_sel)
  );

  tdm_osc_wavetable #(.IDX_W(IDX_W), .SAMP_W(SAMP_W)) i_table (
    .idx(cur_idx), .sel(cur_sel), .sample(cur_sample)
  );

  tdm_osc_out_stage #(.SLOT_W(SLOT_W), .SAMP_W(SAMP_W)) i_out (
    .clk(clk), .rst_n(rst_n), .load(tick), .in_slot(slot), .in_data(cur_sample),
    .out_valid(smp_valid), .out_ready(smp_ready), .out_slot(smp_slot), .out_data(smp_data)
  );

  AST_SERVICE_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> smp_valid && (smp_slot == $past(slot)));  // R7

endmodule

// File: tb/test_tdm_wave_osc.sv
module test_tdm_wave_osc;

  localparam int DIV = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic        cfg_ready;
  logic [3:0]  cfg_slot = '0;
  logic [17:0] cfg_step = '0;
  logic [2:0]  cfg_octave = '0;
  logic [0:0]  cfg_tone = '0;
  logic        smp_valid;
  logic        smp_ready = 1'b1;
  logic [3:0]  smp_slot;
  logic [7:0]  smp_data;

  always #4 clk = ~clk;

  tdm_wave_osc i_tdm_wave_osc (
    .clk(clk), .rst_n(rst_n),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_slot(cfg_slot),
    .cfg_step(cfg_step), .cfg_octave(cfg_octave), .cfg_tone(cfg_tone),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_slot(smp_slot), .smp_data(smp_data)
  );

  typedef struct packed {
    logic [3:0]  s;
    logic [17:0] step;
    logic [2:0]  oct;
    logic        tone;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{4'd0,  18'h00400, 3'd0, 1'b0},
    '{4'd1,  18'h01000, 3'd2, 1'b1},
    '{4'd2,  18'h3FFFF, 3'd7, 1'b1},
    '{4'd3,  18'h20000, 3'd5, 1'b0},
    '{4'd4,  18'h12345, 3'd1, 1'b1},
    '{4'd6,  18'h00001, 3'd3, 1'b1},
    '{4'd7,  18'h0ABCD, 3'd4, 1'b1},
    '{4'd8,  18'h3C000, 3'd6, 1'b0},
    '{4'd9,  18'h00800, 3'd0, 1'b1},
    '{4'd15, 18'h1FFFF, 3'd3, 1'b1},
    '{4'd0,  18'h00000, 3'd0, 1'b1},
    '{4'd2,  18'h04000, 3'd2, 1'b0}
  };

  int n_chk = 0;
  int n_bad = 0;
  bit first_seen = 0;

  logic [17:0] m_ph   [16];
  logic [17:0] m_step [16];
  logic [2:0]  m_oct  [16];
  logic        m_tone [16];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int bsin(input int i);
    int q, p;
    q = i % 128;
    p = (q * (127 - q)) / 32;
    return (i < 128) ? 128 + p : 128 - p;
  endfunction

  function automatic int exp_sample(input logic [17:0] ph, input logic [2:0] oct, input logic tone);
    int i, k, j;
    i = int'(ph[17:10]);
    if (!tone) return bsin(i);
    k = (7 - int'(oct)) / 2;
    j = (i << k) % 256;
    return (bsin(i) + bsin(j)) / 2;
  endfunction

  // Sample stream monitor: phase model advances on every new sample.
  bit         prev_v = 0;
  logic [3:0] prev_slot = '0;
  logic [3:0] exp_slot = '0;
  always @(negedge clk) begin
    if (rst_n && smp_valid && (!prev_v || smp_slot != prev_slot)) begin
      chk(smp_slot == exp_slot, "R2 slot order", int'(smp_slot), int'(exp_slot));
      m_ph[smp_slot] = m_ph[smp_slot] + m_step[smp_slot];
      chk(int'(smp_data) == exp_sample(m_ph[smp_slot], m_oct[smp_slot], m_tone[smp_slot]),
          "R3 R4 R5 R6 sample value", int'(smp_data),
          exp_sample(m_ph[smp_slot], m_oct[smp_slot], m_tone[smp_slot]));
      if (!first_seen) begin
        first_seen = 1;
        chk(smp_slot == 4'd0 && smp_data == 8'd128, "R1 first sample", int'(smp_data), 128);
      end
      exp_slot  = smp_slot + 4'd1;
      prev_slot = smp_slot;
    end
    prev_v = rst_n && smp_valid;
  end

  task automatic load_slot(input vec_t v);
    bit done = 0;
    @(negedge clk);
    cfg_valid = 1'b1; cfg_slot = v.s; cfg_step = v.step; cfg_octave = v.oct; cfg_tone = v.tone;
    while (!done) begin
      #1;
      if (cfg_ready) begin
        @(posedge clk);
        m_step[v.s] = v.step; m_oct[v.s] = v.oct; m_tone[v.s] = v.tone;
        done = 1;
      end
      @(negedge clk);
    end
    cfg_valid = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      m_ph[i] = '0; m_step[i] = '0; m_oct[i] = '0; m_tone[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(smp_valid == 1'b0, "R1 smp_valid after reset", int'(smp_valid), 0);
    chk(cfg_ready == 1'b1, "R1 cfg_ready after reset", int'(cfg_ready), 1);

    // R2: first service SLOT_DIV clocks after release
    repeat (DIV - 2) @(negedge clk);
    chk(smp_valid == 1'b0, "R2 no sample before first service", int'(smp_valid), 0);
    @(negedge clk);
    chk(smp_valid == 1'b1, "R2 R7 sample after first service", int'(smp_valid), 1);

    // Vector table walk
    for (int v = 0; v < 12; v++) begin
      load_slot(VECS[v]);
      repeat (160) @(negedge clk);
    end

    // R9: load lands in the target slot's service clock
    begin
      vec_t cv;
      cv = '{4'd5, 18'h02000, 3'd4, 1'b1};
      do @(negedge clk); while (!(smp_valid && smp_slot == 4'd4));
      repeat (DIV - 1) @(negedge clk);
      cfg_valid = 1'b1; cfg_slot = cv.s; cfg_step = cv.step; cfg_octave = cv.oct; cfg_tone = cv.tone;
      #1;
      chk(cfg_ready == 1'b0, "R9 ready low in service clock", int'(cfg_ready), 0);
      @(negedge clk);
      chk(smp_valid && smp_slot == 4'd5, "R9 blocked clock was slot service", int'(smp_slot), 5);
      #1;
      chk(cfg_ready == 1'b1, "R9 ready back next clock", int'(cfg_ready), 1);
      @(posedge clk);
      m_step[5] = cv.step; m_oct[5] = cv.oct; m_tone[5] = cv.tone;
      @(negedge clk);
      cfg_valid = 1'b0;
      repeat (300) @(negedge clk);
    end

    // R8: back-pressure hold and replacement
    begin
      logic [3:0] s0;
      logic [7:0] d0;
      @(negedge clk);
      smp_ready = 1'b0;
      do @(negedge clk); while (!smp_valid);
      s0 = smp_slot; d0 = smp_data;
      repeat (3) begin
        @(negedge clk);
        if (smp_slot == s0)
          chk(smp_valid && smp_data == d0, "R8 held while stalled", int'(smp_data), int'(d0));
      end
      do @(negedge clk); while (smp_slot == s0);
      chk(smp_valid && smp_slot == s0 + 4'd1, "R8 replaced by next slot", int'(smp_slot), int'(s0 + 4'd1));
      repeat (40) @(negedge clk);
      smp_ready = 1'b1;
      repeat (2 * DIV) @(negedge clk);
      do @(negedge clk); while (!smp_valid);
      @(negedge clk);
      chk(smp_valid == 1'b0, "R8 accepted sample clears", int'(smp_valid), 0);
      repeat (200) @(negedge clk);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule